// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Each cycle it may accept one command, which names an operation and carries the accumulator value and a second operand. It computes the result combinationally from the operands and the carry held in its own status word, then registers both the result and the updated flags. The result register changes only when the operation writes the accumulator, and a one-cycle write strobe marks each such update. The surrounding sequencer owns the accumulator, instruction fetch and memory traffic, and uses the strobe to decide when to take the new value.

The status word is five bits wide. Four of them are arithmetic flags. Each class of operation has its own rule for which flags it computes and which it forces to zero. The sign flag is set when the result is non-negative. The fifth bit is an interrupt-enable bit. Only dedicated set and clear commands, or a load of the whole status word, can change it.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `result` is 0x00, `flags` is 0 and `acc_wr` is 0 after that edge.
- R2: A command presented with `op_vld` high is reflected in `result`, `acc_wr` and `flags` after the next rising edge. With `op_vld` low, `result` and `flags` hold their values and `acc_wr` is 0.
- R3: The status word layout is: bit 4 interrupt enable, bit 3 overflow (O), bit 2 zero (Z), bit 1 carry (C), bit 0 sign (S). S is the inverse of result bit 7, and Z is 1 when the 8-bit result is zero.
- R4: Binary add group, each writing the accumulator and updating O, Z, C and S:
  - code 0 adds the operand;
  - code 1 adds the current C and ignores the operand;
  - code 11 adds one;
  - code 12 adds 0xFF.
  C is the carry out of bit 7. O is set when the two's-complement sum leaves the range -128..127.
- R5: Code 13 (compare) evaluates operand + ~accumulator + 1, which equals operand minus accumulator. It updates O, Z, C and S as an addition does, so C=1 when operand ≥ accumulator unsigned. It leaves `result` unchanged and `acc_wr` at 0.
- R6: Logic group, each writing the accumulator, clearing O and C, and updating Z and S:
  - code 3 is AND;
  - code 4 is OR;
  - code 5 is XOR;
  - code 6 is complement, an XOR with 0xFF that ignores the operand.
- R7: Shift group, each writing the accumulator, filling vacated bits with zeros, clearing O and C, and updating Z and S:
  - code 7 shifts right by one;
  - code 8 shifts left by one;
  - code 9 shifts right by four;
  - code 10 shifts left by four.
  A right shift therefore always leaves S at 1.
- R8: Code 2 (decimal add) writes the packed-BCD sum of two packed-BCD bytes modulo 100. C is the decimal carry (sum ≥ 100), O is cleared, and Z and S follow the written result.
- R9: Code 14 sets the interrupt-enable bit and code 15 clears it. Neither touches the other flags or `result`. No other code except 16 changes the interrupt-enable bit.
- R10: Code 16 loads all five status bits from operand bits 4:0 and does not write the accumulator.
- R11: Codes 17 to 31 have no effect: `result` and `flags` hold their values and `acc_wr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_vld | input | 1 | Command present this cycle |
| op_code | input | 5 | Operation selector |
| acc_in | input | 8 | Current accumulator value |
| opnd_in | input | 8 | Second operand (immediate, memory or scratch byte) |
| result | output | 8 | Registered value to write to the accumulator |
| acc_wr | output | 1 | One-cycle strobe: `result` was just updated |
| flags | output | 5 | Registered status word |

## Verification
The hardest conditions to reach are the ones that depend on stored state, not on the operands of a single command. Add-with-carry uses the carry that an earlier command left behind, so the stimulus has to set up that carry on purpose. It does this once through a status load and once through an add that overflows to zero, and then checks that the carry is added in. Keeping the interrupt-enable bit intact is just as indirect to check. The bit is set first, and a run of arithmetic, logic and compare commands follows, each of which rewrites all four arithmetic flags, with the bit checked after every one. Decimal add is driven at the nibble-carry boundaries: 99+01 and 50+50 both wrap to 00, and 45+38 carries only out of the low nibble.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DW   = 8;
  localparam int NIBS = DW / 4;
  localparam int SW   = 5;
  localparam int OPW  = 5;

  localparam int FB_S  = 0;
  localparam int FB_C  = 1;
  localparam int FB_Z  = 2;
  localparam int FB_O  = 3;
  localparam int FB_IE = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_DADD = 5'd2,
    OP_AND  = 5'd3,
    OP_OR   = 5'd4,
    OP_XOR  = 5'd5,
    OP_COM  = 5'd6,
    OP_SHR1 = 5'd7,
    OP_SHL1 = 5'd8,
    OP_SHR4 = 5'd9,
    OP_SHL4 = 5'd10,
    OP_INC  = 5'd11,
    OP_DEC  = 5'd12,
    OP_CMP  = 5'd13,
    OP_IEON = 5'd14,
    OP_IEOFF= 5'd15,
    OP_LDST = 5'd16
  } op_e;

  typedef enum logic [1:0] {
    FC_KEEP,
    FC_ARITH,
    FC_LOGIC,
    FC_DEC
  } fclass_e;

  typedef enum logic [1:0] {
    RS_ADD,
    RS_BCD,
    RS_LOG
  } rsel_e;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] low;
  logic [W:0]   full;

  // carry into the top bit comes out of the lower W-1 bits
  assign low  = {1'b0, a[W-2:0]} + {1'b0, b[W-2:0]} + {{(W-1){1'b0}}, cin};
  assign full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign sum  = full[W-1:0];
  assign cout = full[W];
  assign ovf  = low[W-1] ^ full[W];
endmodule

// File: rtl/alu_bcd.sv
module alu_bcd #(
  parameter int N = 2
) (
  input  logic [4*N-1:0] a,
  input  logic [4*N-1:0] b,
  output logic [4*N-1:0] sum,
  output logic           cout
);
  logic [N:0] cy;
  assign cy[0] = 1'b0;

  // each nibble is summed with a bias of 6; a nibble that does not carry
  // gets the bias taken back (add 0xA modulo 16)
  for (genvar g = 0; g < N; g++) begin : g_nib
    logic [4:0] raw;
    assign raw = {1'b0, a[4*g +: 4]} + {1'b0, b[4*g +: 4]} + 5'd6 + {4'd0, cy[g]};
    assign cy[g+1] = raw[4];
    assign sum[4*g +: 4] = raw[4] ? raw[3:0] : (raw[3:0] + 4'hA);
  end

  assign cout = cy[N];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_COM:  y = a ^ {W{1'b1}};
      OP_SHR1: y = a >> 1;
      OP_SHL1: y = a << 1;
      OP_SHR4: y = a >> 4;
      OP_SHL4: y = a << 4;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu_status.sv
module alu_status
  import acc_alu_pkg::*;
#(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  fclass_e      fcls,
  input  logic         o_new,
  input  logic         c_new,
  input  logic         z_new,
  input  logic         s_new,
  input  logic         ie_on,
  input  logic         ie_off,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] st_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else if (en) begin
      if (ld) begin
        st_q <= ld_val;
      end else begin
        unique case (fcls)
          FC_ARITH: begin
            st_q[FB_O] <= o_new;
            st_q[FB_C] <= c_new;
            st_q[FB_Z] <= z_new;
            st_q[FB_S] <= s_new;
          end
          FC_LOGIC: begin
            st_q[FB_O] <= 1'b0;
            st_q[FB_C] <= 1'b0;
            st_q[FB_Z] <= z_new;
            st_q[FB_S] <= s_new;
          end
          FC_DEC: begin
            st_q[FB_O] <= 1'b0;
            st_q[FB_C] <= c_new;
            st_q[FB_Z] <= z_new;
            st_q[FB_S] <= s_new;
          end
          default: ;
        endcase
        if (ie_on)  st_q[FB_IE] <= 1'b1;
        if (ie_off) st_q[FB_IE] <= 1'b0;
      end
    end
  end

  // R9: interrupt enable moves only on its own commands or a full load
  assert_ie_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!en || (!ie_on && !ie_off && !ld)) |=> $stable(st_q[FB_IE]));

  // R10: a load copies the operand bits verbatim
  assert_load_R10: assert property (@(posedge clk) disable iff (rst)
    (en && ld) |=> (st_q == $past(ld_val)));
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W   = DW,
  parameter int SWD = SW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_vld,
  input  logic [OPW-1:0] op_code,
  input  logic [W-1:0]   acc_in,
  input  logic [W-1:0]   opnd_in,
  output logic [W-1:0]   result,
  output logic           acc_wr,
  output logic [SWD-1:0] flags
);
  localparam int NB = W / 4;

  op_e          op;
  logic [W-1:0] add_a, add_b, add_y, bcd_y, log_y, y;
  logic         add_ci, add_co, add_ov, bcd_co;
  fclass_e      fcls;
  rsel_e        rsel;
  logic         do_wr, ie_on, ie_off, ld;

  assign op = op_e'(op_code);

  always_comb begin
    add_a  = acc_in;
    add_b  = opnd_in;
    add_ci = 1'b0;
    fcls   = FC_KEEP;
    rsel   = RS_LOG;
    do_wr  = 1'b0;
    ie_on  = 1'b0;
    ie_off = 1'b0;
    ld     = 1'b0;
    case (op)
      OP_ADD:  begin fcls = FC_ARITH; rsel = RS_ADD; do_wr = 1'b1; end
      OP_ADDC: begin add_b = '0; add_ci = flags[FB_C];
                     fcls = FC_ARITH; rsel = RS_ADD; do_wr = 1'b1; end
      OP_INC:  begin add_b = '0; add_ci = 1'b1;
                     fcls = FC_ARITH; rsel = RS_ADD; do_wr = 1'b1; end
      OP_DEC:  begin add_b = '1; fcls = FC_ARITH; rsel = RS_ADD; do_wr = 1'b1; end
      OP_CMP:  begin add_a = opnd_in; add_b = ~acc_in; add_ci = 1'b1;
                     fcls = FC_ARITH; rsel = RS_ADD; end
      OP_DADD: begin fcls = FC_DEC; rsel = RS_BCD; do_wr = 1'b1; end
      OP_AND, OP_OR, OP_XOR, OP_COM,
      OP_SHR1, OP_SHL1, OP_SHR4, OP_SHL4:
               begin fcls = FC_LOGIC; rsel = RS_LOG; do_wr = 1'b1; end
      OP_IEON:  ie_on  = 1'b1;
      OP_IEOFF: ie_off = 1'b1;
      OP_LDST:  ld     = 1'b1;
      default: ;
    endcase
  end

  alu_adder #(.W(W)) u_add (
    .a(add_a), .b(add_b), .cin(add_ci),
    .sum(add_y), .cout(add_co), .ovf(add_ov)
  );

  alu_bcd #(.N(NB)) u_bcd (
    .a(acc_in), .b(opnd_in), .sum(bcd_y), .cout(bcd_co)
  );

  alu_logic #(.W(W)) u_log (
    .op(op), .a(acc_in), .b(opnd_in), .y(log_y)
  );

  always_comb begin
    unique case (rsel)
      RS_ADD:  y = add_y;
      RS_BCD:  y = bcd_y;
      default: y = log_y;
    endcase
  end

  alu_status #(.W(SWD)) u_st (
    .clk(clk), .rst(rst), .en(op_vld), .fcls(fcls),
    .o_new(add_ov),
    .c_new((rsel == RS_BCD) ? bcd_co : add_co),
    .z_new(y == '0),
    .s_new(~y[W-1]),
    .ie_on(ie_on), .ie_off(ie_off), .ld(ld),
    .ld_val(opnd_in[SWD-1:0]),
    .st_q(flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      acc_wr <= 1'b0;
    end else begin
      acc_wr <= op_vld & do_wr;
      if (op_vld && do_wr) result <= y;
    end
  end

  // R3: every written result agrees with the zero and sign flags
  assert_zs_match_R3: assert property (@(posedge clk) disable iff (rst)
    acc_wr |-> (flags[FB_S] == ~result[W-1]) && (flags[FB_Z] == (result == '0)));

  // R5: compare never writes the accumulator
  assert_cmp_nowrite_R5: assert property (@(posedge clk) disable iff (rst)
    (op_vld && op_code == OP_CMP) |=> (!acc_wr && $stable(result)));

  // R6, R7: logic and shift commands leave overflow and carry at zero
  assert_logic_oc_R6: assert property (@(posedge clk) disable iff (rst)
    (op_vld && op_code >= OP_AND && op_code <= OP_SHL4) |=>
      (!flags[FB_O] && !flags[FB_C]));

  // R7: a right shift always reports a non-negative result
  assert_shr_sign_R7: assert property (@(posedge clk) disable iff (rst)
    (op_vld && (op_code == OP_SHR1 || op_code == OP_SHR4)) |=> flags[FB_S]);

  // R2: no command, no write and no flag change
  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !op_vld |=> (!acc_wr && $stable(flags) && $stable(result)));

  // R11: unassigned codes do nothing
  assert_undef_R11: assert property (@(posedge clk) disable iff (rst)
    (op_vld && op_code > OP_LDST) |=> (!acc_wr && $stable(flags)));
endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_vld = 1'b0;
  logic [4:0] op_code = '0;
  logic [7:0] acc_in = '0;
  logic [7:0] opnd_in = '0;
  logic [7:0] result;
  logic       acc_wr;
  logic [4:0] flags;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  logic [7:0] exp_res = '0;
  logic       exp_wr  = 1'b0;
  logic [4:0] exp_fl  = '0;

  always #2 clk = ~clk;

  acc_alu u0 (
    .clk(clk), .rst(rst), .op_vld(op_vld), .op_code(op_code),
    .acc_in(acc_in), .opnd_in(opnd_in),
    .result(result), .acc_wr(acc_wr), .flags(flags)
  );

  task automatic chk(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic set_zs(logic [7:0] r);
    exp_fl[2] = (r == 8'h00);
    exp_fl[0] = ~r[7];
  endtask

  task automatic m_add(logic [7:0] a, logic [7:0] b, logic ci);
    int u;
    int sv;
    u  = int'(a) + int'(b) + int'(ci);
    sv = int'($signed(a)) + int'($signed(b)) + int'(ci);
    exp_res   = 8'(u);
    exp_wr    = 1'b1;
    exp_fl[1] = (u > 255);
    exp_fl[3] = (sv > 127) || (sv < -128);
    set_zs(exp_res);
  endtask

  task automatic m_log(logic [7:0] r);
    exp_res   = r;
    exp_wr    = 1'b1;
    exp_fl[3] = 1'b0;
    exp_fl[1] = 1'b0;
    set_zs(r);
  endtask

  // reference model, written from the requirements
  task automatic model(logic [4:0] op, logic [7:0] a, logic [7:0] b);
    int d;
    int sv;
    logic [7:0] r;
    exp_wr = 1'b0;
    case (op)
      5'd0:  m_add(a, b, 1'b0);
      5'd1:  m_add(a, 8'h00, exp_fl[1]);
      5'd11: m_add(a, 8'h01, 1'b0);
      5'd12: m_add(a, 8'hFF, 1'b0);
      5'd13: begin
        r  = 8'(int'(b) - int'(a));
        sv = int'($signed(b)) - int'($signed(a));
        exp_fl[1] = (b >= a);
        exp_fl[3] = (sv > 127) || (sv < -128);
        set_zs(r);
      end
      5'd3:  m_log(a & b);
      5'd4:  m_log(a | b);
      5'd5:  m_log(a ^ b);
      5'd6:  m_log(~a);
      5'd7:  m_log({1'b0, a[7:1]});
      5'd8:  m_log({a[6:0], 1'b0});
      5'd9:  m_log({4'h0, a[7:4]});
      5'd10: m_log({a[3:0], 4'h0});
      5'd2: begin
        d = 10*int'(a[7:4]) + int'(a[3:0]) + 10*int'(b[7:4]) + int'(b[3:0]);
        exp_res   = {4'((d % 100) / 10), 4'(d % 10)};
        exp_wr    = 1'b1;
        exp_fl[1] = (d >= 100);
        exp_fl[3] = 1'b0;
        set_zs(exp_res);
      end
      5'd14: exp_fl[4] = 1'b1;
      5'd15: exp_fl[4] = 1'b0;
      5'd16: exp_fl = b[4:0];
      default: ;
    endcase
  endtask

  task automatic do_op(string req, logic [4:0] op, logic [7:0] a, logic [7:0] b);
    @(negedge clk);
    op_vld = 1'b1; op_code = op; acc_in = a; opnd_in = b;
    @(negedge clk);
    op_vld = 1'b0;
    model(op, a, b);
    chk(req, "result", int'(result), int'(exp_res));
    chk(req, "acc_wr", int'(acc_wr), int'(exp_wr));
    chk(req, "flags",  int'(flags),  int'(exp_fl));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "result", int'(result), 0);
    chk("R1", "acc_wr", int'(acc_wr), 0);
    chk("R1", "flags",  int'(flags),  0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    op_vld = 1'b0; op_code = 5'd0; acc_in = 8'h33; opnd_in = 8'h44;
    @(negedge clk);
    chk("R2", "idle result", int'(result), int'(exp_res));
    chk("R2", "idle acc_wr", int'(acc_wr), 0);
    chk("R2", "idle flags",  int'(flags),  int'(exp_fl));
  endtask

  task automatic t_add;
    do_op("R4", 5'd0,  8'h7F, 8'h01);
    do_op("R4", 5'd0,  8'hFF, 8'h01);
    do_op("R4", 5'd1,  8'h10, 8'hAA);
    do_op("R4", 5'd12, 8'h00, 8'h00);
    do_op("R4", 5'd12, 8'h01, 8'h00);
    do_op("R4", 5'd11, 8'h7F, 8'h00);
    do_op("R4", 5'd0,  8'h80, 8'h80);
    do_op("R4", 5'd11, 8'hFF, 8'h00);
  endtask

  task automatic t_cmp;
    do_op("R3", 5'd0,  8'h21, 8'h01);
    do_op("R5", 5'd13, 8'h03, 8'h05);
    do_op("R5", 5'd13, 8'h05, 8'h03);
    do_op("R5", 5'd13, 8'h5A, 8'h5A);
    do_op("R5", 5'd13, 8'h01, 8'h80);
  endtask

  task automatic t_logic;
    do_op("R6", 5'd3, 8'hF0, 8'h3C);
    do_op("R6", 5'd4, 8'h00, 8'h00);
    do_op("R6", 5'd5, 8'hAA, 8'h55);
    do_op("R6", 5'd6, 8'h0F, 8'h99);
  endtask

  task automatic t_shift;
    do_op("R7", 5'd7,  8'h81, 8'h00);
    do_op("R7", 5'd8,  8'h81, 8'h00);
    do_op("R7", 5'd9,  8'hF0, 8'h00);
    do_op("R7", 5'd10, 8'h0F, 8'h00);
    do_op("R7", 5'd8,  8'h80, 8'h00);
    do_op("R7", 5'd9,  8'h0F, 8'h00);
  endtask

  task automatic t_bcd;
    do_op("R8", 5'd2, 8'h45, 8'h38);
    do_op("R8", 5'd2, 8'h99, 8'h01);
    do_op("R8", 5'd2, 8'h50, 8'h50);
    do_op("R8", 5'd2, 8'h12, 8'h34);
    do_op("R8", 5'd2, 8'h00, 8'h00);
  endtask

  task automatic t_ie;
    do_op("R9", 5'd14, 8'h00, 8'h00);
    do_op("R9", 5'd0,  8'hFF, 8'h01);
    do_op("R9", 5'd5,  8'h12, 8'h34);
    do_op("R9", 5'd13, 8'h09, 8'h02);
    do_op("R9", 5'd2,  8'h19, 8'h01);
    do_op("R9", 5'd15, 8'h00, 8'h00);
    do_op("R9", 5'd11, 8'h00, 8'h00);
  endtask

  task automatic t_load;
    do_op("R10", 5'd16, 8'h00, 8'hFF);
    do_op("R10", 5'd16, 8'h00, 8'h0A);
    do_op("R10", 5'd16, 8'h00, 8'h02);
    do_op("R4",  5'd1,  8'h00, 8'h00);
  endtask

  task automatic t_undef;
    do_op("R11", 5'd17, 8'h12, 8'h34);
    do_op("R11", 5'd31, 8'hFF, 8'hFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_idle();
    t_add();
    t_cmp();
    t_logic();
    t_shift();
    t_bcd();
    t_ie();
    t_load();
    t_undef();
    t_idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule